// File: doc/BRIEF.md
# Mode-Locked Watchdog Timer

This block is a fail-safe up-counter that software must service at regular intervals. Out of reset it starts running from a programmable reload value and counts up by one per clock. If it reaches all-ones without being serviced, it wraps back to the reload value and raises a one-cycle reset request for the chip's reset logic. A service command reloads the counter and so restarts the interval.

Software can also stop and restart the timer, and it can declare initialization complete. A static mode input decides how much freedom software keeps. In compatible mode, software can stop the timer only until initialization is declared complete. After that, stop commands are dropped for good, until the next reset. In enhanced mode, software can stop and restart the timer at any time. Each command is a one-cycle pulse.

Top module: `wdt_guard`

## Requirements
- R1: After reset, `running_o`=1, `init_done_o`=0, `rst_req_o`=0 and `count_o` equals `reload_i`.
- R2: While running with no service and no restart, `count_o` rises by exactly one each cycle until it reaches all-ones.
- R3: When `count_o` is all-ones, the timer is running and no service is given, the next cycle shows `rst_req_o`=1 and `count_o`=`reload_i`. The request lasts a single cycle unless the counter is all-ones again.
- R4: A service pulse while running makes `count_o`=`reload_i` in the next cycle. A service pulse given while `count_o` is all-ones suppresses the reset request.
- R5: With `mode_enh_i`=0 (compatible), a stop pulse clears `running_o` only while `init_done_o` is 0. Once `init_done_o` is 1, a stop pulse is ignored and counting continues.
- R6: With `mode_enh_i`=1 (enhanced), stop and start pulses take effect regardless of `init_done_o`.
- R7: An init-done pulse sets `init_done_o` in the next cycle. The flag stays set until reset, and further init-done pulses change nothing.
- R8: While stopped, `count_o` holds its value, no reset request is raised, and service pulses are ignored.
- R9: A start pulse while stopped sets `running_o` in the next cycle, with `count_o` still held. One cycle later `count_o` equals `reload_i`, and counting then resumes. If start and stop arrive together, start wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_enh_i | input | 1 | 0 = compatible mode, 1 = enhanced mode |
| reload_i | input | CNT_W | Value loaded into the counter on reset, service, restart and wrap |
| service_i | input | 1 | Service pulse (reload counter) |
| stop_i | input | 1 | Stop pulse |
| start_i | input | 1 | Start pulse |
| init_done_i | input | 1 | End-of-initialization pulse |
| count_o | output | CNT_W | Current counter value |
| running_o | output | 1 | Timer is counting |
| init_done_o | output | 1 | Initialization has been declared complete |
| rst_req_o | output | 1 | One-cycle reset request on overflow |

## Verification
The overflow path is swept across reload values from zero to all-ones with an 8-bit counter. Each sweep point confirms that the wrap happens after exactly all-ones minus reload plus one cycles, which separates an off-by-one in the compare from a wrong reload. The same sequence of stop, start and service pulses is applied once in compatible mode and once in enhanced mode, both before and after init-done. This shows that only the mode and init state decide whether a stop is honoured. Service is tried mid-count and exactly on the all-ones cycle, which checks the priority of service over overflow.

// File: rtl/wdt_pkg.sv
// Package: shared types for the watchdog timer.
package wdt_pkg;
    typedef enum logic {
        MODE_COMPAT   = 1'b0,
        MODE_ENHANCED = 1'b1
    } wdt_mode_e;
endpackage

// File: rtl/wdt_ctrl.sv
// Module: wdt_ctrl
// Turns stop, start and init-done pulses into the running state and a
// one-cycle restart request. Assumes each command is a single-cycle pulse
// and that the mode input is static while the timer runs.
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wdt_mode_e mode,
    input  logic      stop_cmd,
    input  logic      start_cmd,
    input  logic      init_cmd,
    output logic      run_q,
    output logic      restart_q,
    output logic      init_q
);
    logic stop_allowed;

    // Decide whether a stop pulse may take effect in this mode and init state.
    always_comb begin
        stop_allowed = (mode == MODE_ENHANCED) || !init_q;
    end

    // Hold the running state, the sticky init flag and the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= 1'b1;
            init_q    <= 1'b0;
            restart_q <= 1'b0;
        end else begin
            init_q    <= init_q | init_cmd;
            restart_q <= start_cmd && !run_q;
            if (start_cmd)
                run_q <= 1'b1;
            else if (stop_cmd && stop_allowed)
                run_q <= 1'b0;
        end
    end

    // R5
    locked_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_COMPAT && init_q && run_q) |=> run_q);
    // R6
    enh_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ENHANCED && stop_cmd && !start_cmd) |=> !run_q);
    // R7
    init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_cmd |=> init_q);
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Counts up from the reload value while enabled. It wraps to the reload
// value after all-ones and pulses a reset request when it wraps. Assumes
// that service and restart both mean "reload" and that both beat overflow.
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             service,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             req_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Advance, reload or wrap the counter and raise the overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= reload;
            req_q   <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (en) begin
                if (load || service) begin
                    count_q <= reload;
                end else if (count_q == CNT_MAX) begin
                    count_q <= reload;
                    req_q   <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !service && count_q != CNT_MAX)
        |=> count_q == CNT_W'($past(count_q) + 1'b1));
    // R3
    wrap_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && !service && count_q == CNT_MAX)
        |=> (req_q && count_q == $past(reload)));
    // R4
    service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && service) |=> (!req_q && count_q == $past(reload)));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!req_q && count_q == $past(count_q)));
endmodule

// File: rtl/wdt_guard.sv
// Module: wdt_guard (top)
// Watchdog timer whose stop rights depend on the mode and on the init state.
// Assumes one-cycle command pulses and a static mode input.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_enh_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             service_i,
    input  logic             stop_i,
    input  logic             start_i,
    input  logic             init_done_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             init_done_o,
    output logic             rst_req_o
);
    wdt_mode_e mode;
    logic      run_q;
    logic      restart_q;
    logic      init_q;

    // Map the mode pin onto the mode type.
    always_comb begin
        mode = mode_enh_i ? MODE_ENHANCED : MODE_COMPAT;
    end

    wdt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .stop_cmd  (stop_i),
        .start_cmd (start_i),
        .init_cmd  (init_done_i),
        .run_q     (run_q),
        .restart_q (restart_q),
        .init_q    (init_q)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_q),
        .load    (restart_q),
        .service (service_i),
        .reload  (reload_i),
        .count_q (count_o),
        .req_q   (rst_req_o)
    );

    assign running_o   = run_q;
    assign init_done_o = init_q;
endmodule

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_enh = 1'b0;
    logic [W-1:0] reload = '0;
    logic         service = 1'b0;
    logic         stop = 1'b0;
    logic         start = 1'b0;
    logic         init_done = 1'b0;
    logic [W-1:0] count;
    logic         running;
    logic         init_flag;
    logic         req;

    int tests = 0;
    int fails = 0;
    int nreq = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdt_guard #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .mode_enh_i(mode_enh), .reload_i(reload),
        .service_i(service), .stop_i(stop), .start_i(start),
        .init_done_i(init_done), .count_o(count), .running_o(running),
        .init_done_o(init_flag), .rst_req_o(req)
    );

    always @(posedge clk) if (req) nreq <= nreq + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string rq, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic do_reset(int r);
        reload = W'(r);
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        tick();
        sig = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #1;
        // R1 reset state
        do_reset(16);
        chk("R1 count", int'(count), 16);
        chk("R1 running", int'(running), 1);
        chk("R1 init_done", int'(init_flag), 0);
        chk("R1 req", int'(req), 0);

        // R2 plain counting
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R2 step", int'(count), 16 + i);
        end

        // R3 overflow timing swept across reload values
        for (int r = 0; r <= MAXV; r += 17) begin
            do_reset(r);
            for (int k = 0; k < MAXV - r; k++) tick();
            chk("R3 at max", int'(count), MAXV);
            chk("R3 no early req", int'(req), 0);
            tick();
            chk("R3 req pulse", int'(req), 1);
            chk("R3 wrap to reload", int'(count), r);
            if (r != MAXV) begin
                tick();
                chk("R3 pulse ends", int'(req), 0);
                chk("R3 resume", int'(count), r + 1);
            end
        end

        // R4 service mid-count and on the all-ones cycle
        do_reset(8'h40);
        for (int k = 0; k < 10; k++) tick();
        pulse(service);
        chk("R4 service reload", int'(count), 8'h40);
        do_reset(8'hF0);
        for (int k = 0; k < 15; k++) tick();
        chk("R4 at max", int'(count), MAXV);
        pulse(service);
        chk("R4 req suppressed", int'(req), 0);
        chk("R4 reload at max", int'(count), 8'hF0);

        // R5 R8 R9 compatible mode
        mode_enh = 1'b0;
        do_reset(8'h80);
        tick(); tick(); tick();
        pulse(stop);
        chk("R5 stop before init", int'(running), 0);
        chk("R8 last step", int'(count), 8'h84);
        nreq = 0;
        for (int k = 0; k < 300; k++) tick();
        chk("R8 held", int'(count), 8'h84);
        chk("R8 no req", nreq, 0);
        pulse(service);
        chk("R8 service ignored", int'(count), 8'h84);
        pulse(start);
        chk("R9 running", int'(running), 1);
        chk("R9 still held", int'(count), 8'h84);
        tick();
        chk("R9 restart value", int'(count), 8'h80);
        tick();
        chk("R9 resume", int'(count), 8'h81);
        pulse(init_done);
        chk("R7 set", int'(init_flag), 1);
        pulse(stop);
        chk("R5 stop ignored", int'(running), 1);
        chk("R5 counting on", int'(count), 8'h83);
        pulse(init_done);
        chk("R7 repeat", int'(init_flag), 1);
        chk("R7 repeat count", int'(count), 8'h84);
        do_reset(8'h80);
        chk("R7 cleared by reset", int'(init_flag), 0);

        // R6 enhanced mode after init
        mode_enh = 1'b1;
        do_reset(8'h80);
        pulse(init_done);
        pulse(stop);
        chk("R6 stop after init", int'(running), 0);
        pulse(start);
        chk("R6 start", int'(running), 1);
        tick();
        chk("R6 restart value", int'(count), 8'h80);
        // R9 start beats stop
        pulse(stop);
        stop = 1'b1;
        start = 1'b1;
        tick();
        stop = 1'b0;
        start = 1'b0;
        chk("R9 start wins", int'(running), 1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule